// File: doc/BRIEF.md
# Aligned Block Instruction Fetch Stage

This block is the front-end fetch stage of a four-wide superscalar core with fixed 32-bit instructions. Each cycle it presents one naturally aligned 16-byte block address to a combinational instruction memory port. The returned block goes into a register as four instruction slots, each with its own valid bit and program counter. Slots that lie below the entry point of a fetch are marked invalid. This happens when the entry is a branch target that falls partway into a block.

A redirect carries a branch target. It steers the address port to the aligned block that holds the target in the same cycle, and it replaces the sequential block that would otherwise be taken. After any delivered block, fetch moves on to the next 16-byte block with all four slots valid. While the consumer is not ready, the stage holds its slots and does not advance. There is no unaligned fetch. A four-instruction loop whose top is 16-byte aligned streams at one block per cycle. The same loop with its top at byte offset 12 needs two fetch cycles per iteration.

Top module: `fetch_unit`

## Requirements
- R1: While rst_ni is low, all slot valid bits are 0 and imem_addr_o equals the reset PC with its low 4 bits cleared (0 by default).
- R2: In a cycle with redirect_valid_i high, imem_addr_o equals redirect_target_i with bits [3:0] cleared. Otherwise it is the aligned sequential fetch address.
- R3: In the block delivered after a redirect, slot i (bit i of slot_valid_o) is valid exactly when i >= redirect_target_i[3:2]. Valid bits are therefore contiguous up to slot 3.
- R4: When a block has been delivered and no redirect comes, the next delivered block has base PC = previous base + 16 (wrapping modulo 2^32), with all four slots valid.
- R5: Slot i's instruction (slot_insn_o[32i+:32]) equals imem_rdata_i[32i+:32] of the block fetched. Slot 0 holds the lowest address.
- R6: slot_pc_o[32i+:32] equals the block base address + 4*i.
- R7: A redirect takes priority over sequential advance and over a low ready_i. The sequential block in flight is never delivered, and the target block appears at the next clock edge.
- R8: While ready_i is low and no redirect is present, the slot instructions, valids and PCs stay unchanged, and so does imem_addr_o.
- R9: An aligned four-instruction loop redirected every cycle delivers four valid slots per cycle. A loop whose top is at byte offset 12 delivers one valid slot and then four, which is two fetch cycles per iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| redirect_valid_i | input | 1 | Branch target redirect request |
| redirect_target_i | input | 32 | Redirect target byte address |
| ready_i | input | 1 | Consumer accepts the current slots |
| imem_addr_o | output | 32 | Aligned 16-byte block address to instruction memory |
| imem_rdata_i | input | 128 | Block read data, slot 0 in the low word |
| slot_insn_o | output | 128 | Four delivered instructions |
| slot_valid_o | output | 4 | Per-slot valid, bit i for slot i |
| slot_pc_o | output | 128 | Four slot PCs, slot 0 in the low word |

## Verification
A corrupted fetch PC register shows up at once on imem_addr_o. One edge later it shows up as a slot PC base that breaks the +16 sequence. A wrong entry offset or a bad mask compare shows in slot_valid_o on the first block after the redirect, as a gap or a wrong count of leading invalid slots. A hold or priority fault shows as slot contents that change while ready is low, or as a sequential block delivered where the target block should be. Each of these is visible within one cycle of the stimulus that causes it.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned INSN_LSB   = 2;
endpackage

// File: rtl/fu_entry_mask.sv
module fu_entry_mask #(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned OFF_BITS = $clog2(SLOTS)
) (
  input  logic [OFF_BITS-1:0] offset_i,
  output logic [SLOTS-1:0]    mask_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign mask_o[g] = (g >= int'(offset_i));
  end
endmodule

// File: rtl/fu_pc_seq.sv
module fu_pc_seq #(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       BLK_BITS = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              redirect_valid_i,
  input  logic [ADDR_W-1:0] redirect_target_i,
  input  logic              advance_i,
  output logic [ADDR_W-1:0] sel_pc_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(1) << BLK_BITS;

  logic [ADDR_W-1:0] fetch_pc_q;

  assign sel_pc_o = redirect_valid_i ? redirect_target_i : fetch_pc_q;
  assign base_o   = {sel_pc_o[ADDR_W-1:BLK_BITS], {BLK_BITS{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fetch_pc_q <= RESET_PC;
    else if (advance_i) fetch_pc_q <= base_o + BLK_STEP;
  end

  // redirect must force a load (R7)
  p_redirect_loads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_i |-> advance_i);

  // sequential path restarts one block past the target (R7)
  p_redirect_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_i |=> fetch_pc_q ==
      {$past(redirect_target_i[ADDR_W-1:BLK_BITS]), {BLK_BITS{1'b0}}} + BLK_STEP);
endmodule

// File: rtl/fu_slot_out.sv
module fu_slot_out #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [SLOTS*INSN_W-1:0] insn_i,
  input  logic [SLOTS-1:0]        mask_i,
  input  logic [ADDR_W-1:0]       base_i,
  output logic [SLOTS*INSN_W-1:0] slot_insn_o,
  output logic [SLOTS-1:0]        slot_valid_o,
  output logic [SLOTS*ADDR_W-1:0] slot_pc_o
);
  import fetch_pkg::*;

  logic [SLOTS*INSN_W-1:0] insn_q;
  logic [SLOTS-1:0]        valid_q;
  logic [ADDR_W-1:0]       base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insn_q  <= '0;
      valid_q <= '0;
      base_q  <= '0;
    end else if (load_i) begin
      insn_q  <= insn_i;
      valid_q <= mask_i;
      base_q  <= base_i;
    end
  end

  assign slot_insn_o  = insn_q;
  assign slot_valid_o = valid_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_pc
    assign slot_pc_o[g*ADDR_W +: ADDR_W] = base_q + ADDR_W'(g * INSN_BYTES);
  end

  // any valid run must reach the top slot (R3)
  p_contig_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q != '0) |-> valid_q[SLOTS-1]);
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
  parameter int unsigned       SLOTS    = 4,
  parameter int unsigned       INSN_W   = 32,
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    redirect_valid_i,
  input  logic [ADDR_W-1:0]       redirect_target_i,
  input  logic                    ready_i,
  output logic [ADDR_W-1:0]       imem_addr_o,
  input  logic [SLOTS*INSN_W-1:0] imem_rdata_i,
  output logic [SLOTS*INSN_W-1:0] slot_insn_o,
  output logic [SLOTS-1:0]        slot_valid_o,
  output logic [SLOTS*ADDR_W-1:0] slot_pc_o
);
  import fetch_pkg::*;

  localparam int unsigned OFF_BITS  = $clog2(SLOTS);
  localparam int unsigned BLK_BYTES = SLOTS * INSN_BYTES;
  localparam int unsigned BLK_BITS  = $clog2(BLK_BYTES);

  logic              load;
  logic [ADDR_W-1:0] sel_pc, base;
  logic [SLOTS-1:0]  mask;

  assign load        = redirect_valid_i | ready_i;
  assign imem_addr_o = base;

  fu_pc_seq #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .RESET_PC(RESET_PC)) u_seq (
    .clk_i, .rst_ni,
    .redirect_valid_i, .redirect_target_i,
    .advance_i (load),
    .sel_pc_o  (sel_pc),
    .base_o    (base)
  );

  fu_entry_mask #(.SLOTS(SLOTS), .OFF_BITS(OFF_BITS)) u_mask (
    .offset_i (sel_pc[BLK_BITS-1:INSN_LSB]),
    .mask_o   (mask)
  );

  fu_slot_out #(.SLOTS(SLOTS), .INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_out (
    .clk_i, .rst_ni,
    .load_i  (load),
    .insn_i  (imem_rdata_i),
    .mask_i  (mask),
    .base_i  (base),
    .slot_insn_o, .slot_valid_o, .slot_pc_o
  );

  p_redirect_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_i |=> slot_pc_o[ADDR_W-1:0] ==
      {$past(redirect_target_i[ADDR_W-1:BLK_BITS]), {BLK_BITS{1'b0}}});

  p_entry_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_i |=> slot_valid_o ==
      SLOTS'({SLOTS{1'b1}} << $past(redirect_target_i[BLK_BITS-1:INSN_LSB])));

  p_seq_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !redirect_valid_i && slot_valid_o != '0) |=>
      (&slot_valid_o) &&
      slot_pc_o[ADDR_W-1:0] == $past(slot_pc_o[ADDR_W-1:0]) + ADDR_W'(BLK_BYTES));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_i && !redirect_valid_i) |=>
      $stable(slot_valid_o) && $stable(slot_insn_o) && $stable(slot_pc_o));
endmodule

// File: tb/sim_fetch_unit.sv
module sim_fetch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NV         = 15;

  typedef struct packed {
    logic        rd;
    logic [31:0] tgt;
    logic        rdy;
    logic [31:0] addr;
    logic [3:0]  vld;
    logic [31:0] base;
    logic [3:0]  tag;
  } vec_t;

  // rd, target, ready, expected imem_addr, expected valids, expected base, req
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,        1'b1, 32'h0,        4'b1111, 32'h0,        4'd4}, // R4 first block
    '{1'b1, 32'h10C,      1'b1, 32'h100,      4'b1000, 32'h100,      4'd3}, // R3 offset 12
    '{1'b0, 32'h0,        1'b1, 32'h110,      4'b1111, 32'h110,      4'd4}, // R4
    '{1'b1, 32'h10C,      1'b1, 32'h100,      4'b1000, 32'h100,      4'd9}, // R9 unaligned loop
    '{1'b0, 32'h0,        1'b1, 32'h110,      4'b1111, 32'h110,      4'd9},
    '{1'b1, 32'h200,      1'b1, 32'h200,      4'b1111, 32'h200,      4'd3}, // R3 offset 0
    '{1'b1, 32'h200,      1'b1, 32'h200,      4'b1111, 32'h200,      4'd9}, // R9 aligned loop
    '{1'b0, 32'h0,        1'b0, 32'h210,      4'b1111, 32'h200,      4'd8}, // R8 hold
    '{1'b0, 32'h0,        1'b0, 32'h210,      4'b1111, 32'h200,      4'd8},
    '{1'b0, 32'h0,        1'b1, 32'h210,      4'b1111, 32'h210,      4'd4},
    '{1'b1, 32'h348,      1'b0, 32'h340,      4'b1100, 32'h340,      4'd7}, // R7 beats low ready
    '{1'b1, 32'h404,      1'b1, 32'h400,      4'b1110, 32'h400,      4'd3},
    '{1'b0, 32'h0,        1'b1, 32'h410,      4'b1111, 32'h410,      4'd4},
    '{1'b1, 32'hFFFF_FFF4, 1'b1, 32'hFFFF_FFF0, 4'b1110, 32'hFFFF_FFF0, 4'd3},
    '{1'b0, 32'h0,        1'b1, 32'h0,        4'b1111, 32'h0,        4'd4}  // R4 wrap
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         redirect_valid_i = 1'b0;
  logic [31:0]  redirect_target_i = '0;
  logic         ready_i = 1'b0;
  logic [31:0]  imem_addr_o;
  logic [127:0] imem_rdata_i;
  logic [127:0] slot_insn_o;
  logic [3:0]   slot_valid_o;
  logic [127:0] slot_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++)
      imem_rdata_i[i*32 +: 32] = mem_word(imem_addr_o + 32'(i*4));
  end

  fetch_unit u0 (
    .clk_i, .rst_ni, .redirect_valid_i, .redirect_target_i, .ready_i,
    .imem_addr_o, .imem_rdata_i, .slot_insn_o, .slot_valid_o, .slot_pc_o
  );

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_block(input logic [3:0] vld, input logic [31:0] base, input string req);
    logic [31:0] ep, ei;
    bit pc_ok = 1'b1, in_ok = 1'b1;
    chk(slot_valid_o == vld, req, "slot_valid", 32'(slot_valid_o), 32'(vld));
    for (int i = 0; i < 4; i++) begin
      ep = base + 32'(i*4);
      ei = mem_word(ep);
      if (slot_pc_o[i*32 +: 32] != ep) begin
        pc_ok = 1'b0;
        $display("  slot %0d pc mismatch", i);
      end
      if (slot_insn_o[i*32 +: 32] != ei) begin
        in_ok = 1'b0;
        $display("  slot %0d insn mismatch", i);
      end
    end
    chk(pc_ok, "R6", "slot_pc[0]", slot_pc_o[31:0], base);
    chk(in_ok, "R5", "slot_insn[0]", slot_insn_o[31:0], mem_word(base));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_i);
    chk(slot_valid_o == 4'b0, "R1", "valid in reset", 32'(slot_valid_o), 32'h0);
    chk(imem_addr_o == 32'h0, "R1", "addr in reset", imem_addr_o, 32'h0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      redirect_valid_i  = VECS[k].rd;
      redirect_target_i = VECS[k].tgt;
      ready_i           = VECS[k].rdy;
      #1;
      chk(imem_addr_o == VECS[k].addr, "R2", "imem_addr", imem_addr_o, VECS[k].addr);
      @(posedge clk_i);
      #1;
      chk_block(VECS[k].vld, VECS[k].base, tag_name(VECS[k].tag));
    end

    // R8: held outputs with ready low across several cycles
    @(negedge clk_i);
    redirect_valid_i = 1'b0;
    ready_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk_block(4'b1111, 32'h0, "R8");
    chk(imem_addr_o == 32'h10, "R8", "addr held", imem_addr_o, 32'h10);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(slot_valid_o == 4'b0, "R1", "valid after reset", 32'(slot_valid_o), 32'h0);
    chk(imem_addr_o == 32'h0, "R1", "addr after reset", imem_addr_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7: redirect on the first cycle out of reset wins over the reset block
    redirect_valid_i  = 1'b1;
    redirect_target_i = 32'h508;
    ready_i           = 1'b1;
    @(posedge clk_i);
    #1;
    chk_block(4'b1100, 32'h500, "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule